// File: doc/BRIEF.md
# Peripheral Module Stop Controller

This block holds a 16-bit control word in which every bit can halt one on-chip peripheral while the processor keeps running. Software writes the word over a simple register bus with one write strobe per byte. A written value is held as pending and reaches the peripherals only at a bus cycle boundary, marked by an end-of-cycle strobe. The block never stalls the processor.

From the applied word the block derives a run-enable per peripheral, a state-clear for the peripherals that lose their contents while halted, and a gate on register accesses aimed at each peripheral. Reads of a halted peripheral return a fixed fill value, and writes to it are dropped. A sleep request is passed on one cycle later unless the control word holds a pattern that would halt the bus controller. In that case an error flag is raised instead.

Bit positions: 15 DMA engine, 14 transfer controller, 13 16-bit timer, 12 8-bit timer, 11 pulse-pattern generator, 10 DAC, 9 ADC, 7/6/5 serial channels 2/1/0. Bits 8 and 4..0 are spare.

Top module: `modstop_ctrl`

## Requirements
- R1: After reset the register reads 0x3FFF, `run_en` is 0xC000 (only bits 15 and 14 running) and `state_clr` is 0x02E0.
- R2: A write with `reg_sel` and `reg_wr` high updates bits 15..8 when `reg_be[1]` is set and bits 7..0 when `reg_be[0]` is set, both in the same edge. `reg_rdata` returns the written value from the next cycle, even before it has been applied.
- R3: The pending word is copied to the applied word on an edge where `cyc_end` is high. The copy uses the value held before that edge, so a write on the same edge applies at a later strobe. For bits 15..9 and 7..5, `run_en` is the inverse of the applied stop bit. Without `cyc_end`, `run_en` does not change.
- R4: Spare bits 8 and 4..0 store and read back what is written, but `run_en` and `state_clr` stay 0 at those positions.
- R5: `state_clr` bits 9, 7, 6 and 5 are high exactly while the matching module is stopped in the applied word. All other `state_clr` bits are 0.
- R6: An access (`acc_rd` or `acc_wr`) to module index `acc_idx` raises bit `acc_idx` of `acc_rd_en` or `acc_wr_en` only if that module is running. A stopped or spare target gets no enable.
- R7: When `acc_rd` is high and the target is not running, `acc_rdata_out` is the fill value 0x0000. Otherwise it passes `acc_rdata_in` through.
- R8: One cycle after `slp_req`, `slp_fwd` goes high, unless the register held 0xFFFF or 0xEFFF at that edge. In that case `slp_err` goes high and `slp_fwd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Control register selected |
| reg_wr | input | 1 | Register write |
| reg_be | input | 2 | Byte write strobes (1 high, 0 low) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Pending register value |
| cyc_end | input | 1 | End-of-bus-cycle strobe |
| run_en | output | 16 | Per-module run enable |
| state_clr | output | 16 | Per-module state clear |
| acc_idx | input | 4 | Index of peripheral being accessed |
| acc_rd | input | 1 | Peripheral read request |
| acc_wr | input | 1 | Peripheral write request |
| acc_rdata_in | input | 16 | Read data from peripherals |
| acc_rd_en | output | 16 | Gated read enables |
| acc_wr_en | output | 16 | Gated write enables |
| acc_rdata_out | output | 16 | Read data toward the bus |
| slp_req | input | 1 | Sleep request |
| slp_fwd | output | 1 | Sleep request passed on |
| slp_err | output | 1 | Forbidden stop pattern on sleep |

## Verification
Access gating and the read fill are combinational on the applied word, so they are due in the same cycle as the access and are sampled 1 ns after the inputs change. The register read-back is due one edge after a write. The applied word, `run_en` and `state_clr` are due one edge after a `cyc_end` edge and hold the pending value from before that edge. The sleep outputs are due one edge after the request. The bench updates its model at each rising edge, using the values held before that edge, and compares at the next falling edge. Random stimulus is mixed with directed cases for both forbidden patterns, for a write that coincides with a strobe, and for single-byte writes.

// File: rtl/modstop_ctrl.sv
module modstop_ctrl #(
  parameter int          W        = 16,
  parameter logic [15:0] RST_VAL  = 16'h3FFF,
  parameter logic [15:0] USED     = 16'hFEE0,
  parameter logic [15:0] LOSE     = 16'h02E0,
  parameter logic [15:0] RD_FILL  = 16'h0000,
  parameter logic [15:0] BAD_A    = 16'hFFFF,
  parameter logic [15:0] BAD_B    = 16'hEFFF,
  localparam int         NB       = W / 8,
  localparam int         IW       = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [NB-1:0] reg_be,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          cyc_end,
  output logic [W-1:0]  run_en,
  output logic [W-1:0]  state_clr,
  input  logic [IW-1:0] acc_idx,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [W-1:0]  acc_rdata_in,
  output logic [W-1:0]  acc_rd_en,
  output logic [W-1:0]  acc_wr_en,
  output logic [W-1:0]  acc_rdata_out,
  input  logic          slp_req,
  output logic          slp_fwd,
  output logic          slp_err
);

  logic [W-1:0] pend, appl, tgt;
  logic         bad, tgt_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RST_VAL;
    end else if (reg_sel && reg_wr) begin
      for (int b = 0; b < NB; b++)
        if (reg_be[b]) pend[b*8 +: 8] <= reg_wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       appl <= RST_VAL;
    else if (cyc_end) appl <= pend;
  end

  assign bad = (pend == BAD_A) || (pend == BAD_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_fwd <= 1'b0;
      slp_err <= 1'b0;
    end else begin
      slp_fwd <= slp_req && !bad;
      slp_err <= slp_req && bad;
    end
  end

  assign reg_rdata     = pend;
  assign run_en        = ~appl & USED;
  assign state_clr     = appl & LOSE;
  assign tgt           = {{(W-1){1'b0}}, 1'b1} << acc_idx;
  assign tgt_on        = |(tgt & run_en);
  assign acc_rd_en     = acc_rd ? (tgt & run_en) : '0;
  assign acc_wr_en     = acc_wr ? (tgt & run_en) : '0;
  assign acc_rdata_out = (acc_rd && !tgt_on) ? RD_FILL : acc_rdata_in;

endmodule

// File: rtl/modstop_ctrl_chk.sv
module modstop_ctrl_chk #(
  parameter logic [15:0] USED    = 16'hFEE0,
  parameter logic [15:0] LOSE    = 16'h02E0,
  parameter logic [15:0] RD_FILL = 16'h0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_end,
  input logic [15:0] reg_rdata,
  input logic [15:0] run_en,
  input logic [15:0] state_clr,
  input logic        acc_rd,
  input logic [15:0] acc_rd_en,
  input logic [15:0] acc_wr_en,
  input logic [15:0] acc_rdata_out,
  input logic        slp_fwd,
  input logic        slp_err
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(run_en));

  assert_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> run_en == (~$past(reg_rdata) & USED));

  assert_spare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_en | state_clr) & ~USED) == 16'h0);

  assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state_clr == (~run_en & LOSE));

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_rd_en) && $onehot0(acc_wr_en));

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd_en | acc_wr_en) & ~run_en) == 16'h0);

  assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_rd_en == 16'h0) |-> acc_rdata_out == RD_FILL);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(slp_fwd && slp_err));

endmodule

bind modstop_ctrl modstop_ctrl_chk #(
  .USED(USED), .LOSE(LOSE), .RD_FILL(RD_FILL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .reg_rdata(reg_rdata),
  .run_en(run_en), .state_clr(state_clr), .acc_rd(acc_rd),
  .acc_rd_en(acc_rd_en), .acc_wr_en(acc_wr_en),
  .acc_rdata_out(acc_rdata_out), .slp_fwd(slp_fwd), .slp_err(slp_err)
);

// File: tb/modstop_ctrl_test.sv
module modstop_ctrl_test;
  localparam int CLK_P = 10;
  localparam logic [15:0] USED = 16'hFEE0;
  localparam logic [15:0] LOSE = 16'h02E0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0, cyc_end = 0, acc_rd = 0, acc_wr = 0, slp_req = 0;
  logic [1:0]  reg_be = 0;
  logic [15:0] reg_wdata = 0, acc_rdata_in = 0;
  logic [3:0]  acc_idx = 0;
  logic [15:0] reg_rdata, run_en, state_clr, acc_rd_en, acc_wr_en, acc_rdata_out;
  logic        slp_fwd, slp_err;

  int tests = 0, fails = 0;
  logic [15:0] m_pend = 16'h3FFF, m_appl = 16'h3FFF;
  logic        m_fwd = 0, m_err = 0;

  always #(CLK_P/2) clk = ~clk;

  modstop_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_end(cyc_end), .run_en(run_en),
    .state_clr(state_clr), .acc_idx(acc_idx), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_rdata_in(acc_rdata_in), .acc_rd_en(acc_rd_en), .acc_wr_en(acc_wr_en),
    .acc_rdata_out(acc_rdata_out), .slp_req(slp_req), .slp_fwd(slp_fwd), .slp_err(slp_err)
  );

  function automatic logic [15:0] exp_run(input logic [15:0] a); return ~a & USED; endfunction
  function automatic logic [15:0] exp_clr(input logic [15:0] a); return a & LOSE; endfunction
  function automatic logic [15:0] exp_en(input logic req, input logic [3:0] i, input logic [15:0] a);
    logic [15:0] t = 16'h1 << i;
    return req ? (t & exp_run(a)) : 16'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 readback"}, reg_rdata, m_pend);
    check({tag, " R3 run_en"}, run_en, exp_run(m_appl));
    check({tag, " R5 state_clr"}, state_clr, exp_clr(m_appl));
    check({tag, " R6 rd_en"}, acc_rd_en, exp_en(acc_rd, acc_idx, m_appl));
    check({tag, " R6 wr_en"}, acc_wr_en, exp_en(acc_wr, acc_idx, m_appl));
    check({tag, " R7 rdata"}, acc_rdata_out,
          (acc_rd && exp_en(1'b1, acc_idx, m_appl) == 16'h0) ? 16'h0000 : acc_rdata_in);
    check({tag, " R8 sleep"}, {14'h0, slp_fwd, slp_err}, {14'h0, m_fwd, m_err});
  endtask

  task automatic step(input logic w, input logic [1:0] be, input logic [15:0] d,
                      input logic ce, input logic [3:0] idx, input logic rd,
                      input logic wr, input logic [15:0] rin, input logic sr,
                      input string tag);
    logic bad;
    reg_sel = w; reg_wr = w; reg_be = be; reg_wdata = d; cyc_end = ce;
    acc_idx = idx; acc_rd = rd; acc_wr = wr; acc_rdata_in = rin; slp_req = sr;
    #1;
    check_all(tag);
    @(posedge clk);
    bad = (m_pend == 16'hFFFF) || (m_pend == 16'hEFFF);
    m_fwd = sr && !bad;
    m_err = sr && bad;
    if (ce) m_appl = m_pend;
    if (w) begin
      if (be[1]) m_pend[15:8] = d[15:8];
      if (be[0]) m_pend[7:0]  = d[7:0];
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset reg", reg_rdata, 16'h3FFF);
    check("R1 reset run", run_en, 16'hC000);
    check("R1 reset clr", state_clr, 16'h02E0);
    @(negedge clk);

    // R2/R3: write clears all, applied only on next strobe
    step(1, 2'b11, 16'h0000, 0, 4'd13, 1, 0, 16'hA5A5, 0, "dir");
    step(0, 2'b00, 16'h0000, 0, 4'd13, 1, 0, 16'hA5A5, 0, "dir hold");
    step(0, 2'b00, 16'h0000, 1, 4'd9, 1, 1, 16'h1234, 0, "dir apply");
    step(0, 2'b00, 16'h0000, 0, 4'd8, 1, 1, 16'h1234, 0, "dir R4 spare");
    // R2: high byte only, then low byte only
    step(1, 2'b10, 16'h02FF, 0, 4'd7, 1, 0, 16'h5555, 0, "dir hi");
    step(1, 2'b01, 16'hFF1F, 0, 4'd5, 1, 0, 16'h5555, 0, "dir lo");
    // R3: write coincident with strobe applies old value
    step(1, 2'b11, 16'hFFE0, 1, 4'd9, 1, 0, 16'h7777, 0, "dir same");
    step(0, 2'b00, 16'h0000, 1, 4'd9, 1, 0, 16'h7777, 0, "dir R5");
    // R8: forbidden patterns and a legal one
    step(1, 2'b11, 16'hFFFF, 0, 4'd0, 0, 0, 16'h0, 1, "dir R8 a");
    step(0, 2'b00, 16'h0000, 0, 4'd0, 0, 0, 16'h0, 1, "dir R8 ffff");
    step(1, 2'b11, 16'hEFFF, 0, 4'd0, 0, 0, 16'h0, 0, "dir R8 b");
    step(0, 2'b00, 16'h0000, 0, 4'd0, 0, 0, 16'h0, 1, "dir R8 efff");
    step(1, 2'b11, 16'hDFFF, 1, 4'd0, 0, 0, 16'h0, 0, "dir R8 c");
    step(0, 2'b00, 16'h0000, 0, 4'd14, 1, 0, 16'h0, 1, "dir R8 ok");
    step(0, 2'b00, 16'h0000, 0, 4'd14, 1, 0, 16'h0, 0, "dir R8 done");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      case ($urandom % 5)
        0: d = 16'hFFFF;
        1: d = 16'hEFFF;
        2: d = 16'h0000;
        default: d = 16'($urandom);
      endcase
      step(($urandom % 4) == 0, 2'($urandom), d, ($urandom % 3) == 0,
           4'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
           ($urandom % 4) == 0, "rnd");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule